// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash device. It watches the host's write strobe, address and data bus. It takes the address when the strobe is asserted and the data when the strobe is released, so each completed host write becomes one internal command cycle. From those cycles it recognises a two-write unlock key followed by an operation byte. The result is a mode: array read, identification (autoselect), or program set-up. When a program command completes, it sends a single-cycle start pulse, with the target address and data, to the internal program/erase controller.

The same block steers the read-data path. In array-read and program set-up modes, reads return the array data unchanged. In identification mode, low address lines select one of three results: the manufacturer code, the device code, or the protect flag of the block addressed by the upper address bits. The protect flags come in as a vector on a port. A reset byte returns the device to array read. It is accepted with or without the unlock key, but it is refused while an erase or an erase suspend is reported as in progress.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (array read) and `pg_go` is low. In any mode other than identification (2'b01), `rd_data` equals `array_data`.
- R2: The writes AAh@555h, then 55h@2AAh, then 90h@555h set `mode_o` to 2'b01 (identification). Only the low 12 address bits are compared in each of these writes; bits 19:12 can hold any value.
- R3: A write whose address or data does not match the next expected key or operation step drops the sequence back to idle. It starts no program and leaves `mode_o` unchanged. A later complete key still works.
- R4: A write of F0h to any address, whether or not the unlock key comes first, sets `mode_o` to 2'b00 when `erase_busy` is low.
- R5: While `erase_busy` is high, a write of F0h leaves `mode_o` unchanged.
- R6: In identification mode, a read with A1=0 and A0=0 returns 20h.
- R7: In identification mode, a read with A1=0 and A0=1 returns the device code: EAh when `TOP_BOOT`=1, EBh when `TOP_BOOT`=0.
- R8: In identification mode, a read with A1=1, A0=0 and A6=0 returns `{7'b0, blk_prot[A19:A13]}`. Every other identification address returns 00h.
- R9: The writes AAh@555h, then 55h@2AAh, then A0h@555h set `mode_o` to 2'b10 (program set-up). The next write of any value, F0h included, does the following:
  - it raises `pg_go` for exactly one cycle;
  - `pg_addr` carries the address seen at strobe assertion;
  - `pg_data` carries the data seen at strobe release;
  - `mode_o` returns to 2'b00.
- R10: Decoding happens after the clock edge that first sees the strobe low. `mode_o` and `pg_go` take their new values on the edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Host write strobe, active high |
| wr_addr | input | 20 | Host address, taken when the strobe rises |
| wr_data | input | 8 | Host data, taken when the strobe falls |
| erase_busy | input | 1 | An erase or an erase suspend is in progress |
| rd_addr | input | 20 | Read address |
| array_data | input | 8 | Data read from the memory array |
| blk_prot | input | 128 | Protect flag for each block, indexed by address bits 19:13 |
| rd_data | output | 8 | Read data returned to the host |
| mode_o | output | 2 | 00 array read, 01 identification, 10 program set-up |
| pg_go | output | 1 | One-cycle program start pulse |
| pg_addr | output | 20 | Program target address |
| pg_data | output | 8 | Program data byte |

## Verification
The assertions assume that every strobe high phase and every low phase lasts at least one clock. This means no two command cycles complete on consecutive clocks. The stimulus keeps to that: each strobe level is held for two clocks. It also changes the address and data away from their sample points, so that a design sampling at the wrong moment produces visibly wrong values. Read addresses change only on the falling clock edge, so the read multiplexer checks see stable inputs.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'b00,
    MD_IDENT = 2'b01,
    MD_PSET  = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_KEY1 = 2'b01,
    SQ_KEY2 = 2'b10
  } seq_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] CODE_MFR   = 8'h20;
  localparam logic [7:0] CODE_TOP   = 8'hEA;
  localparam logic [7:0] CODE_BOT   = 8'hEB;

  localparam int unsigned KEY_ADDR_A = 'h555;
  localparam int unsigned KEY_ADDR_B = 'h2AA;

endpackage

// File: rtl/fcd_strobe_capture.sv
module fcd_strobe_capture #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_strobe,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cyc_ok,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);

  logic          strobe_q;
  logic [AW-1:0] addr_hold;
  logic          rise, fall;

  assign rise = wr_strobe & ~strobe_q;
  assign fall = ~wr_strobe & strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      addr_hold <= '0;
      cyc_ok    <= 1'b0;
      cyc_addr  <= '0;
      cyc_data  <= '0;
    end else begin
      strobe_q <= wr_strobe;
      cyc_ok   <= fall;
      if (rise) addr_hold <= wr_addr;
      if (fall) begin
        cyc_addr <= addr_hold;
        cyc_data <= wr_data;
      end
    end
  end

  AST_CYCLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ok |=> !cyc_ok); // R10

  AST_CYCLE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ok |-> !strobe_q); // R10

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 8,
  parameter int CMD_AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_ok,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic          erase_busy,
  output mode_e         mode,
  output logic          pg_go,
  output logic [AW-1:0] pg_addr,
  output logic [DW-1:0] pg_data
);

  localparam logic [CMD_AW-1:0] ADDR_A = CMD_AW'(KEY_ADDR_A);
  localparam logic [CMD_AW-1:0] ADDR_B = CMD_AW'(KEY_ADDR_B);

  seq_e              seq;
  logic [CMD_AW-1:0] low_addr;
  logic              hit_a, hit_b;

  assign low_addr = cyc_addr[CMD_AW-1:0];
  assign hit_a    = (low_addr == ADDR_A);
  assign hit_b    = (low_addr == ADDR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq     <= SQ_IDLE;
      mode    <= MD_ARRAY;
      pg_go   <= 1'b0;
      pg_addr <= '0;
      pg_data <= '0;
    end else begin
      pg_go <= 1'b0;
      if (cyc_ok) begin
        if (mode == MD_PSET) begin
          pg_go   <= 1'b1;
          pg_addr <= cyc_addr;
          pg_data <= cyc_data;
          mode    <= MD_ARRAY;
          seq     <= SQ_IDLE;
        end else if (cyc_data == OP_RESET) begin
          if (!erase_busy) begin
            mode <= MD_ARRAY;
            seq  <= SQ_IDLE;
          end
        end else begin
          case (seq)
            SQ_IDLE: seq <= (hit_a && cyc_data == KEY_FIRST) ? SQ_KEY1 : SQ_IDLE;
            SQ_KEY1: seq <= (hit_b && cyc_data == KEY_SECOND) ? SQ_KEY2 : SQ_IDLE;
            SQ_KEY2: begin
              seq <= SQ_IDLE;
              if (hit_a && cyc_data == OP_IDENT) mode <= MD_IDENT;
              else if (hit_a && cyc_data == OP_PROG) mode <= MD_PSET;
            end
            default: seq <= SQ_IDLE;
          endcase
        end
      end
    end
  end

  AST_GO_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |-> $past(mode) == MD_PSET); // R9

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |=> !pg_go); // R9

  AST_IDENT_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && $past(mode) != MD_IDENT) |-> $past(cyc_ok)); // R2

  AST_RESET_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && cyc_data == OP_RESET && !erase_busy && mode != MD_PSET) |=> mode == MD_ARRAY); // R4

  AST_RESET_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && cyc_data == OP_RESET && erase_busy && mode != MD_PSET) |=> $stable(mode)); // R5

  AST_MODE_ONLY_ON_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_ok) |-> $stable(mode)); // R10

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int BLK_LSB  = 13,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  mode_e                          mode,
  input  logic [AW-1:0]                  rd_addr,
  input  logic [DW-1:0]                  array_data,
  input  logic [(1 << (AW-BLK_LSB))-1:0] blk_prot,
  output logic [DW-1:0]                  rd_data
);

  localparam int         NBLK     = 1 << (AW - BLK_LSB);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? CODE_TOP : CODE_BOT;

  logic [AW-BLK_LSB-1:0] blk_idx;
  logic [DW-1:0]         ident_data;
  logic                  prot_bit;

  assign blk_idx  = rd_addr[AW-1:BLK_LSB];
  assign prot_bit = blk_prot[blk_idx];

  always_comb begin
    ident_data = '0;
    unique case ({rd_addr[1], rd_addr[0]})
      2'b00: ident_data = DW'(CODE_MFR);
      2'b01: ident_data = DW'(DEV_CODE);
      2'b10: ident_data = rd_addr[6] ? '0 : DW'(prot_bit);
      default: ident_data = '0;
    endcase
  end

  assign rd_data = (mode == MD_IDENT) ? ident_data : array_data;

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_IDENT) |-> rd_data == array_data); // R1

  AST_MFR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && rd_addr[1:0] == 2'b00) |-> rd_data == DW'(8'h20)); // R6

  AST_PROT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && rd_addr[1]) |-> rd_data[DW-1:1] == '0); // R8

  initial begin
    AST_BLOCK_COUNT: assert (NBLK >= 2); // R8
  end

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import fcd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int CMD_AW   = 12,
  parameter int BLK_LSB  = 13,
  parameter bit TOP_BOOT = 1'b1,
  localparam int NBLK    = 1 << (AW - BLK_LSB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_strobe,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            erase_busy,
  input  logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   array_data,
  input  logic [NBLK-1:0] blk_prot,
  output logic [DW-1:0]   rd_data,
  output logic [1:0]      mode_o,
  output logic            pg_go,
  output logic [AW-1:0]   pg_addr,
  output logic [DW-1:0]   pg_data
);

  logic          cyc_ok;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  mode_e         mode;

  fcd_strobe_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cyc_ok    (cyc_ok),
    .cyc_addr  (cyc_addr),
    .cyc_data  (cyc_data)
  );

  fcd_seq_fsm #(.AW(AW), .DW(DW), .CMD_AW(CMD_AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_ok     (cyc_ok),
    .cyc_addr   (cyc_addr),
    .cyc_data   (cyc_data),
    .erase_busy (erase_busy),
    .mode       (mode),
    .pg_go      (pg_go),
    .pg_addr    (pg_addr),
    .pg_data    (pg_data)
  );

  fcd_read_mux #(.AW(AW), .DW(DW), .BLK_LSB(BLK_LSB), .TOP_BOOT(TOP_BOOT)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .rd_addr    (rd_addr),
    .array_data (array_data),
    .blk_prot   (blk_prot),
    .rd_data    (rd_data)
  );

  assign mode_o = mode;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11); // R1

endmodule

// File: tb/flash_cmd_front_test.sv
`timescale 1ns/1ps
module flash_cmd_front_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_strobe = 1'b0;
  logic [19:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         erase_busy = 1'b0;
  logic [19:0]  rd_addr = '0;
  logic [7:0]   array_data = 8'h5A;
  logic [127:0] blk_prot = '0;
  logic [7:0]   rd_data;
  logic [1:0]   mode_o;
  logic         pg_go;
  logic [19:0]  pg_addr;
  logic [7:0]   pg_data;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int programs = 0;

  always #4 clk = ~clk;

  flash_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_busy(erase_busy), .rd_addr(rd_addr),
    .array_data(array_data), .blk_prot(blk_prot), .rd_data(rd_data),
    .mode_o(mode_o), .pg_go(pg_go), .pg_addr(pg_addr), .pg_data(pg_data)
  );

  always @(negedge clk) if (rst_n && pg_go) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one host write; returns on the negedge where results are visible (R10)
  task automatic hwrite(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_strobe = 1'b1; wr_addr = a; wr_data = ~d;
    @(negedge clk);
    wr_addr = ~a; wr_data = d;
    @(negedge clk);
    wr_strobe = 1'b0;
    @(negedge clk);
    wr_data = ~d;
    @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] hi);
    hwrite({hi, 12'h555}, 8'hAA);
    hwrite({hi, 12'h2AA}, 8'h55);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 2'b00);
    chk("R1 go", pg_go, 1'b0);
    for (int v = 0; v < 256; v += 51) begin
      array_data = v[7:0]; #1;
      chk("R1 pass", rd_data, v[7:0]);
    end

    // R2 / R4: identification entry with high bits varied, reset with and without key
    for (int h = 0; h < 256; h += 37) begin
      unlock(h[7:0] ^ 8'h5C);
      hwrite({h[7:0], 12'h555}, 8'h90);
      chk("R2 ident", mode_o, 2'b01);
      array_data = 8'h77; rd_addr = 20'h00001; #1;
      chk("R7 dev", rd_data, 8'hEA);
      if (h % 2 == 0) begin
        hwrite({h[7:0], 12'h123}, 8'hF0);
      end else begin
        unlock(h[7:0]);
        hwrite(20'hFFFFF, 8'hF0);
      end
      chk("R4 reset", mode_o, 2'b00);
      #1 chk("R1 pass back", rd_data, 8'h77);
    end

    // R6 R7 R8: sweep A0/A1/A6 across all blocks, two protect patterns
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 128; b++) blk_prot[b] = (((b * 37 + p * 11) >> 2) & 1) != 0;
      unlock(8'h00);
      hwrite(20'h00555, 8'h90);
      chk("R2 ident sweep", mode_o, 2'b01);
      for (int b = 0; b < 128; b++) begin
        for (int c = 0; c < 8; c++) begin
          logic [7:0] exp;
          @(negedge clk);
          rd_addr = {b[6:0], 13'h0};
          rd_addr[0] = c[0]; rd_addr[1] = c[1]; rd_addr[6] = c[2];
          rd_addr[12] = 1'b1;
          #1;
          if (c[1:0] == 2'b00) exp = 8'h20;
          else if (c[1:0] == 2'b01) exp = 8'hEA;
          else if (c[1:0] == 2'b10 && !c[2]) exp = {7'b0, blk_prot[b]};
          else exp = 8'h00;
          if (c[1:0] == 2'b00) chk("R6 mfr", rd_data, exp);
          else if (c[1:0] == 2'b01) chk("R7 dev", rd_data, exp);
          else chk("R8 prot", rd_data, exp);
        end
      end
      hwrite(20'h00000, 8'hF0);
    end

    // R3: wrong first-cycle data never reaches identification
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hAA || d == 8'hF0) continue;
      hwrite(20'h00555, d[7:0]);
      hwrite(20'h002AA, 8'h55);
      hwrite(20'h00555, 8'h90);
      chk("R3 bad data", mode_o, 2'b00);
    end
    // R3: wrong addresses in each step, from array mode
    hwrite(20'h00556, 8'hAA); hwrite(20'h002AA, 8'h55); hwrite(20'h00555, 8'h90);
    chk("R3 bad addr1", mode_o, 2'b00);
    hwrite(20'h00555, 8'hAA); hwrite(20'h002AB, 8'h55); hwrite(20'h00555, 8'h90);
    chk("R3 bad addr2", mode_o, 2'b00);
    unlock(8'h00); hwrite(20'h00554, 8'hA0);
    chk("R3 bad addr3", mode_o, 2'b00);
    unlock(8'h00); hwrite(20'h00555, 8'h91);
    chk("R3 bad op", mode_o, 2'b00);
    // R3: a broken sequence in identification mode keeps the mode, key still works
    unlock(8'h00); hwrite(20'h00555, 8'h90);
    hwrite(20'h00555, 8'hAA); hwrite(20'h00555, 8'h55);
    chk("R3 keep ident", mode_o, 2'b01);
    unlock(8'h00); hwrite(20'h00555, 8'h77);
    chk("R3 keep ident2", mode_o, 2'b01);
    chk("R3 no start", pulses, 0);

    // R5: reset refused while erase is busy, with and without key
    erase_busy = 1'b1;
    hwrite(20'h00000, 8'hF0);
    chk("R5 plain", mode_o, 2'b01);
    unlock(8'h3);
    hwrite(20'h00555, 8'hF0);
    chk("R5 keyed", mode_o, 2'b01);
    erase_busy = 1'b0;
    hwrite(20'h00000, 8'hF0);
    chk("R4 after busy", mode_o, 2'b00);

    // R9: program sequences
    for (int k = 0; k < 10; k++) begin
      logic [19:0] ta;
      logic [7:0]  td;
      ta = 20'(k * 20'h1A3C5 + 20'h0F0F1);
      td = (k == 9) ? 8'hF0 : 8'(k * 29 + 3);
      unlock(8'(k));
      hwrite({8'(k * 3), 12'h555}, 8'hA0);
      chk("R9 setup", mode_o, 2'b10);
      array_data = 8'(k); #1;
      chk("R1 pass setup", rd_data, 8'(k));
      chk("R9 idle", pg_go, 1'b0);
      hwrite(ta, td);
      programs++;
      chk("R9 go", pg_go, 1'b1);
      chk("R9 addr", pg_addr, ta);
      chk("R9 data", pg_data, td);
      chk("R9 mode back", mode_o, 2'b00);
      @(negedge clk);
      chk("R9 one cycle", pg_go, 1'b0);
    end
    chk("R9 pulse count", pulses, programs);

    // R10: nothing happens on the first edge after strobe release
    unlock(8'h00);
    @(negedge clk); wr_strobe = 1'b1; wr_addr = 20'h00555; wr_data = 8'h90;
    @(negedge clk); wr_strobe = 1'b0;
    @(negedge clk);
    chk("R10 early", mode_o, 2'b00);
    @(negedge clk);
    chk("R10 on time", mode_o, 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule